// File: doc/BRIEF.md
# Interleaved Phase Ring Slot with Light-Load Bypass

One instance of this cell sits at each position of a ring of interleaved converter phases. All cells share one system clock. A single-cycle token enters on `phs_in`. The cell holds it for exactly one system clock in a token register and passes it on through `phs_out`. The cycle in which the token sits in the register is this phase's turn, and the cell flags it on `pwm_start`. The system clock runs at the phase count times the switching frequency, so each phase fires once per trip of the token around the ring.

An active-low light-load request (`lp_req_n`) asks the phase to shut down. The cell synchronizes the request and then qualifies it over eight token periods, counted as rising edges of a synchronized copy of `phs_in`. Once the request is qualified, the cell enters bypass:

- the token register is shorted out, so `phs_out` follows `phs_in` combinationally and the active phases still share the ring evenly;
- the gate drivers are tri-stated;
- the local current report is cut off from the shared current bus.

A debug isolation input comes from an external comparator. It holds the drivers low and disconnects the current report, but leaves the token timing unchanged.

Control is a three-state machine:

- **ST_ACTIVE**: normal operation.
  - Goes to ST_QUALIFY when the synchronized request is seen low.
- **ST_QUALIFY**: counting token edges.
  - Returns to ST_ACTIVE when the request is released. Release takes priority over a coinciding edge.
  - Goes to ST_BYPASS on the eighth counted edge.
- **ST_BYPASS**: flag set.
  - Returns to ST_ACTIVE on release.

Both exits to ST_ACTIVE clear the counter.

Top module: `phs_slot_cell`

## Requirements
- R1: While reset is asserted and after its release, `phs_out`, `pwm_start`, `drv_tristate`, `drv_force_low`, `share_disconnect` and `bypass_active` are all 0, provided `phs_in` is low and `dbg_iso` is low.
- R2: Outside bypass, `phs_out` after each rising clock edge equals the value `phs_in` had at that edge (one-clock delay). `pwm_start` equals that same delayed token while debug isolation is off.
- R3: `bypass_active` is still 0 after the edge following the clock edge that samples the eighth qualifying `phs_in` pulse, and becomes 1 on the edge after that. The request (`lp_req_n` = 0) must have been held and seen by the machine before the first of the eight pulses.
- R4: Seven qualifying pulses never set `bypass_active`. A release of the request during qualification discards the pulses already counted.
- R5: After `lp_req_n` returns to 1, `bypass_active` stays 1 through the first two rising edges and is 0 after the third.
- R6: While `bypass_active` is 1, `phs_out` equals `phs_in` within the same cycle, and `pwm_start` is 0.
- R7: While `bypass_active` is 1, both `drv_tristate` and `share_disconnect` are 1.
- R8: With bypass off, `dbg_iso` = 1 raises `drv_force_low` and `share_disconnect` after the second rising edge that samples it, and forces `pwm_start` to 0. The one-clock `phs_in` to `phs_out` delay is unchanged.
- R9: When bypass and debug isolation are both active, `drv_tristate` is 1, `drv_force_low` is 0 and `share_disconnect` is 1.
- R10: If the request release and the eighth qualifying pulse reach the state machine in the same cycle, the release wins and `bypass_active` never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared system clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| phs_in | input | 1 | Token from the previous ring position |
| lp_req_n | input | 1 | Light-load shutdown request, active low |
| dbg_iso | input | 1 | Debug isolation comparator result, active high |
| phs_out | output | 1 | Token to the next ring position |
| pwm_start | output | 1 | Enable that starts this phase's PWM cycle |
| drv_tristate | output | 1 | Gate drivers to high impedance |
| drv_force_low | output | 1 | Gate drivers held low |
| share_disconnect | output | 1 | Detach current report from the shared bus |
| bypass_active | output | 1 | Qualified light-load flag (register bypassed) |

## Verification
Two events can land in the same cycle: the request release and the eighth qualifying token edge. The bench provokes this by driving the eighth token pulse and the release of `lp_req_n` on the same clock, so both synchronizers deliver them together. It then judges that `bypass_active` stays 0 for the following cycles.

A second overlap puts debug isolation on top of bypass. There the bench checks that the tri-state request wins over the force-low request while the bus stays disconnected.

// File: rtl/phs_slot_pkg.sv
package phs_slot_pkg;

    // Control states of the slot
    typedef enum logic [1:0] {
        ST_ACTIVE  = 2'd0,
        ST_QUALIFY = 2'd1,
        ST_BYPASS  = 2'd2
    } slot_state_t;

    // Default number of token periods that qualify a light-load request
    localparam int unsigned QUAL_PERIODS_DEF = 8;

    // Default synchronizer depth
    localparam int unsigned SYNC_STAGES_DEF = 2;

endpackage

// File: rtl/phs_slot_sync.sv
module phs_slot_sync #(
    parameter int unsigned WIDTH   = 3,
    parameter int unsigned STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] chain_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= RST_VAL;
                    else        chain_q[s] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= RST_VAL;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/phs_slot_qual.sv
module phs_slot_qual
    import phs_slot_pkg::*;
#(
    parameter int unsigned QUAL_PERIODS = QUAL_PERIODS_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tok_sync_i,   // synchronized phase input
    input  logic req_sync_n_i, // synchronized request, active low
    output logic bypass_o,
    output logic qualifying_o
);

    localparam int unsigned CNT_W = (QUAL_PERIODS > 2) ? $clog2(QUAL_PERIODS) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(QUAL_PERIODS - 1);

    slot_state_t      state_q, state_nx;
    logic [CNT_W-1:0] cnt_q, cnt_nx;
    logic             tok_prev_q;
    logic             tok_edge;

    // Rising-edge detect on the synchronized token
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tok_prev_q <= 1'b0;
        else        tok_prev_q <= tok_sync_i;
    end

    assign tok_edge = tok_sync_i & ~tok_prev_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ACTIVE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_nx;
            cnt_q   <= cnt_nx;
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state_q;
        cnt_nx   = cnt_q;
        unique case (state_q)
            ST_ACTIVE: begin
                cnt_nx = '0;
                if (!req_sync_n_i) state_nx = ST_QUALIFY;
            end
            ST_QUALIFY: begin
                if (req_sync_n_i) begin
                    // release wins over a coinciding edge
                    state_nx = ST_ACTIVE;
                    cnt_nx   = '0;
                end else if (tok_edge) begin
                    if (cnt_q == CNT_LAST) begin
                        state_nx = ST_BYPASS;
                        cnt_nx   = '0;
                    end else begin
                        cnt_nx = cnt_q + 1'b1;
                    end
                end
            end
            ST_BYPASS: begin
                cnt_nx = '0;
                if (req_sync_n_i) state_nx = ST_ACTIVE;
            end
            default: begin
                state_nx = ST_ACTIVE;
                cnt_nx   = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        bypass_o     = 1'b0;
        qualifying_o = 1'b0;
        unique case (state_q)
            ST_ACTIVE:  ;
            ST_QUALIFY: qualifying_o = 1'b1;
            ST_BYPASS:  bypass_o     = 1'b1;
            default:    ;
        endcase
    end

endmodule

// File: rtl/phs_slot_token.sv
module phs_slot_token (
    input  logic clk,
    input  logic rst_n,
    input  logic tok_i,
    input  logic bypass_i,
    input  logic quiet_i,   // suppress local start (debug isolation)
    output logic tok_o,
    output logic start_o
);

    logic tok_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tok_q <= 1'b0;
        else        tok_q <= tok_i;
    end

    always_comb begin
        if (bypass_i) begin
            tok_o   = tok_i;
            start_o = 1'b0;
        end else begin
            tok_o   = tok_q;
            start_o = tok_q & ~quiet_i;
        end
    end

endmodule

// File: rtl/phs_slot_cell.sv
module phs_slot_cell
    import phs_slot_pkg::*;
#(
    parameter int unsigned QUAL_PERIODS = QUAL_PERIODS_DEF,
    parameter int unsigned SYNC_STAGES  = SYNC_STAGES_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic phs_in,
    input  logic lp_req_n,
    input  logic dbg_iso,
    output logic phs_out,
    output logic pwm_start,
    output logic drv_tristate,
    output logic drv_force_low,
    output logic share_disconnect,
    output logic bypass_active
);

    localparam int unsigned SYNC_W = 3;
    // bit 0: token, bit 1: request (idles high), bit 2: debug
    localparam logic [SYNC_W-1:0] SYNC_RST = 3'b010;

    logic [SYNC_W-1:0] sync_q;
    logic              bypass;
    logic              qualifying;
    logic              dbg_s;

    phs_slot_sync #(
        .WIDTH   (SYNC_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({dbg_iso, lp_req_n, phs_in}),
        .q_o   (sync_q)
    );

    assign dbg_s = sync_q[2];

    phs_slot_qual #(
        .QUAL_PERIODS (QUAL_PERIODS)
    ) qual_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .tok_sync_i   (sync_q[0]),
        .req_sync_n_i (sync_q[1]),
        .bypass_o     (bypass),
        .qualifying_o (qualifying)
    );

    phs_slot_token token_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tok_i    (phs_in),
        .bypass_i (bypass),
        .quiet_i  (dbg_s),
        .tok_o    (phs_out),
        .start_o  (pwm_start)
    );

    // Driver and bus control; tri-state wins over force-low
    always_comb begin
        drv_tristate     = 1'b0;
        drv_force_low    = 1'b0;
        share_disconnect = 1'b0;
        if (bypass) begin
            drv_tristate     = 1'b1;
            share_disconnect = 1'b1;
        end else if (dbg_s) begin
            drv_force_low    = 1'b1;
            share_disconnect = 1'b1;
        end else if (qualifying) begin
            share_disconnect = 1'b0;
        end
    end

    assign bypass_active = bypass;

endmodule

// File: rtl/phs_slot_chk.sv
module phs_slot_chk (
    input logic clk,
    input logic rst_n,
    input logic phs_in,
    input logic lp_req_n,
    input logic dbg_iso,
    input logic phs_out,
    input logic pwm_start,
    input logic drv_tristate,
    input logic drv_force_low,
    input logic share_disconnect,
    input logic bypass_active
);

    logic [1:0] up_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        up_q <= 2'd0;
        else if (up_q != 2'd3) up_q <= up_q + 2'd1;
    end

    // R2: one-clock delay of the token outside bypass
    a_r2_token_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (up_q == 2'd3 && !bypass_active && !$past(bypass_active))
            |-> (phs_out == $past(phs_in)));

    // R3: bypass only rises on a request held low
    a_r3_rise_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        (up_q == 2'd3 && $rose(bypass_active)) |-> !$past(lp_req_n, 3));

    // R5: bypass only falls on a released request
    a_r5_fall_needs_release: assert property (@(posedge clk) disable iff (!rst_n)
        (up_q == 2'd3 && $fell(bypass_active)) |-> $past(lp_req_n, 3));

    // R6: no local start while bypassed
    a_r6_no_start_in_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        bypass_active |-> !pwm_start);

    // R7: bypass tri-states drivers and detaches the report
    a_r7_bypass_isolates: assert property (@(posedge clk) disable iff (!rst_n)
        bypass_active |-> (drv_tristate && share_disconnect));

    // R9: tri-state and force-low never together
    a_r9_tristate_wins: assert property (@(posedge clk) disable iff (!rst_n)
        drv_tristate |-> !drv_force_low);

endmodule

bind phs_slot_cell phs_slot_chk chk_i (.*);

// File: tb/phs_slot_cell_tb_top.sv
`timescale 1ns/1ps
module phs_slot_cell_tb_top;

    localparam int QUAL = 8;

    logic clk = 1'b0;
    logic rst_n, phs_in, lp_req_n, dbg_iso;
    logic phs_out, pwm_start, drv_tristate, drv_force_low, share_disconnect, bypass_active;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    phs_slot_cell #(.QUAL_PERIODS(QUAL)) dut_i (
        .clk(clk), .rst_n(rst_n), .phs_in(phs_in), .lp_req_n(lp_req_n),
        .dbg_iso(dbg_iso), .phs_out(phs_out), .pwm_start(pwm_start),
        .drv_tristate(drv_tristate), .drv_force_low(drv_force_low),
        .share_disconnect(share_disconnect), .bypass_active(bypass_active)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // One token pulse; checks bypass on the two edges after sampling
    task automatic pulse(input string req, input int idx);
        phs_in = 1'b1;
        step();
        phs_in = 1'b0;
        step();
        chk({req, " bypass one edge after sample"}, bypass_active, 0);
        step();
        chk({req, " bypass two edges after sample"}, bypass_active, (idx >= QUAL) ? 1 : 0);
        step();
    endtask

    // Exhaustive 4-bit token patterns; phs_out and start follow one clock late
    task automatic sweep(input string req, input int start_en);
        for (int pat = 0; pat < 16; pat++) begin
            int prev = 0;
            for (int i = 0; i < 4; i++) begin
                phs_in = pat[i];
                step();
                chk({req, " phs_out delayed"}, phs_out, pat[i]);
                chk({req, " pwm_start"}, pwm_start, start_en ? pat[i] : 0);
                prev = pat[i];
            end
            phs_in = 1'b0;
            step();
            chk({req, " phs_out tail"}, phs_out, 0);
        end
    endtask

    initial begin
        rst_n = 1'b0; phs_in = 1'b0; lp_req_n = 1'b1; dbg_iso = 1'b0;
        step(3);
        // R1 reset state
        chk("R1 phs_out", phs_out, 0);
        chk("R1 pwm_start", pwm_start, 0);
        chk("R1 drv_tristate", drv_tristate, 0);
        chk("R1 drv_force_low", drv_force_low, 0);
        chk("R1 share_disconnect", share_disconnect, 0);
        chk("R1 bypass_active", bypass_active, 0);
        rst_n = 1'b1;
        step(2);
        chk("R1 bypass after release", bypass_active, 0);

        // R2 token delay sweep
        sweep("R2", 1);

        // R3/R4 qualification over eight pulses
        lp_req_n = 1'b0;
        step(6);
        for (int p = 1; p <= QUAL; p++) pulse((p < QUAL) ? "R4" : "R3", p);
        chk("R3 bypass set", bypass_active, 1);

        // R6/R7 pass-through and isolation in bypass
        phs_in = 1'b1;
        #1;
        chk("R6 phs_out follows high", phs_out, 1);
        chk("R6 pwm_start low", pwm_start, 0);
        chk("R7 drv_tristate", drv_tristate, 1);
        chk("R7 share_disconnect", share_disconnect, 1);
        step();
        chk("R6 pwm_start low after edge", pwm_start, 0);
        phs_in = 1'b0;
        #1;
        chk("R6 phs_out follows low", phs_out, 0);
        step();

        // R9 debug on top of bypass
        dbg_iso = 1'b1;
        step(3);
        chk("R9 drv_tristate", drv_tristate, 1);
        chk("R9 drv_force_low", drv_force_low, 0);
        chk("R9 share_disconnect", share_disconnect, 1);
        dbg_iso = 1'b0;
        step(3);

        // R5 release timing
        lp_req_n = 1'b1;
        step(2);
        chk("R5 bypass held two edges", bypass_active, 1);
        step();
        chk("R5 bypass cleared third edge", bypass_active, 0);
        chk("R5 tristate cleared", drv_tristate, 0);
        step(2);

        // R8 debug isolation alone
        dbg_iso = 1'b1;
        step();
        chk("R8 force_low not yet", drv_force_low, 0);
        step();
        chk("R8 drv_force_low", drv_force_low, 1);
        chk("R8 share_disconnect", share_disconnect, 1);
        chk("R8 drv_tristate", drv_tristate, 0);
        sweep("R8", 0);
        dbg_iso = 1'b0;
        step(3);
        chk("R8 force_low released", drv_force_low, 0);

        // R4 abandoned qualification discards count
        lp_req_n = 1'b0;
        step(6);
        for (int p = 1; p <= 5; p++) pulse("R4", p);
        lp_req_n = 1'b1;
        step(6);
        lp_req_n = 1'b0;
        step(6);
        for (int p = 1; p < QUAL; p++) pulse("R4", p);
        chk("R4 seven pulses after restart", bypass_active, 0);
        pulse("R3", QUAL);
        lp_req_n = 1'b1;
        step(4);
        chk("R5 bypass cleared", bypass_active, 0);

        // R10 release coincides with the eighth pulse
        lp_req_n = 1'b0;
        step(6);
        for (int p = 1; p < QUAL; p++) pulse("R10", p);
        phs_in = 1'b1;
        lp_req_n = 1'b1;
        step();
        phs_in = 1'b0;
        for (int i = 0; i < 5; i++) begin
            step();
            chk("R10 release wins", bypass_active, 0);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual 0 expected 1 (run completed)");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule